// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a byte-wide serial EEPROM that sits on a two-wire bus as a target. It oversamples the bus clock and data lines with the system clock and recognises the start and stop conditions. It matches a device-select byte against two strap pins, so up to four of these devices can share one bus. It accepts a two-byte word address and then either takes write data or returns read data. Acknowledges and read data leave on an open-drain enable: when the enable is high, the board pulls the data line low.

Writes do not touch the array directly. Each incoming data byte lands in a page buffer inside a self-timed commit engine. A stop condition then starts a commit, which holds the device busy for a fixed number of clocks. While the commit runs, the device ignores its own select byte. A controller can therefore keep retrying the select byte and learn from the acknowledge when the write has finished. Reads come straight from the array through an address counter that advances after every byte. The counter wraps at the top of the address space.

The array is 16K bytes wide in address (14-bit word address), or 32K bytes (15-bit) when the large variant is chosen. The backing store is a parameterised slice of that space, and the upper address bits alias onto it.

Top module: `eeprom_twi_target`

## Requirements
- R1: After synchronous reset the device releases the data line (`sda_oe_o` = 0), sits idle, and is not busy.
- R2: A start (data falls while clock is high) at any point, including in the middle of a byte, restarts reception at the select byte. A stop (data rises while clock is high) returns the device to idle with the data line released.
- R3: The select byte is sent MSB first. Bits 7:4 are 1010, bit 3 is 0, bits 2:1 equal `strap_i`, and bit 0 is read (1) or write (0). Only a match is acknowledged. A device that is not selected stays silent until the next start.
- R4: The device acknowledges each accepted byte by pulling data low for the ninth clock. It changes its data drive only while the clock is low.
- R5: The word address follows a write select as two bytes, high byte first. Only the low 14 bits (15 for the large variant) are kept, and the upper bits are ignored.
- R6: Data bytes after the word address are stored at successive locations. The low 6 bits (64-byte page) wrap inside the page, and the page bits stay fixed. One to 64 bytes may be written.
- R7: A stop after at least one data byte starts a commit lasting `WR_CYCLES` clocks. During the commit the select byte is not acknowledged. A write that carries only an address starts no commit.
- R8: A read select with no preceding address returns the byte at the internal counter, which is one past the last byte read.
- R9: A random read consists of a write select, two address bytes, a repeated start and a read select. The first byte returned is the one at that address.
- R10: Reading continues while the controller acknowledges each byte, and a missing acknowledge ends it. The counter advances after every byte read and wraps from the top address to 0.
- R11: The backing store is indexed by the low `STORE_AW` (default 10) address bits, so addresses that differ only above them alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Device-select strap value |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
Single-byte writes followed by random reads are driven from a table. The table includes addresses with junk in the don't-care upper bits, which separates correct address masking from a device that keeps the bits. A four-byte page read with acknowledges, and a read across the top address, tell counter advance and wrap apart from a counter that stalls or overflows. A page write that runs off the end of its page shows whether the offset wraps inside the page or spills into the next one. Polling the select byte right after a stop, after a data-less write, and with a foreign strap value separates the busy, idle and not-selected cases. A start inserted in the middle of a byte checks that framing restarts.

// File: rtl/eeprom_twi_pkg.sv
package eeprom_twi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        STP_DEV,
        STP_AHI,
        STP_ALO,
        STP_DATA
    } step_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    function automatic logic dev_match(input logic [7:0] sel, input logic [1:0] strap);
        return (sel[7:4] == DEV_TYPE) && !sel[3] && (sel[2:1] == strap);
    endfunction

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync
    import eeprom_twi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [2:0] scl_pipe;
    logic [2:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= 3'b111;
            sda_pipe <= 3'b111;
        end else begin
            scl_pipe <= {scl_pipe[1:0], scl_i};
            sda_pipe <= {sda_pipe[1:0], sda_i};
        end
    end

    always_comb begin
        ev.scl   = scl_pipe[1];
        ev.sda   = sda_pipe[1];
        ev.rise  = scl_pipe[1] && !scl_pipe[2];
        ev.fall  = !scl_pipe[1] && scl_pipe[2];
        ev.start = scl_pipe[1] && scl_pipe[2] && sda_pipe[2] && !sda_pipe[1];
        ev.stop  = scl_pipe[1] && scl_pipe[2] && !sda_pipe[2] && sda_pipe[1];
    end

endmodule

// File: rtl/twi_commit_engine.sv
module twi_commit_engine #(
    parameter int ADDR_W    = 14,
    parameter int STORE_AW  = 10,
    parameter int PAGE_AW   = 6,
    parameter int WR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [7:0]        push_data_i,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o
);

    localparam int PAGE     = 1 << PAGE_AW;
    localparam int DEPTH    = 1 << STORE_AW;
    localparam int PG_W     = ADDR_W - PAGE_AW;
    localparam int IDX_W    = PAGE_AW + 1;
    localparam int TMR_W    = $clog2(WR_CYCLES + 1);
    localparam int RUN_LEN  = (WR_CYCLES > PAGE + 1) ? WR_CYCLES : PAGE + 1;

    logic [7:0]        store [DEPTH];
    logic [7:0]        pbuf  [PAGE];
    logic              valid_q [PAGE];
    logic [PG_W-1:0]   page_q;
    logic              pend_q;
    logic              busy_q;
    logic [TMR_W:0]    tmr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              clear;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_full;
    logic [PAGE_AW-1:0] push_off;

    assign push_off = push_addr_i[PAGE_AW-1:0];
    assign clear    = busy_q && (tmr_q == (TMR_W+1)'(RUN_LEN - 1));
    assign wr_full  = {page_q, idx_q[PAGE_AW-1:0]};
    assign wr_en    = busy_q && !idx_q[PAGE_AW] && valid_q[idx_q[PAGE_AW-1:0]];

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                pbuf[g]    <= 8'h00;
            end else if (clear) begin
                valid_q[g] <= 1'b0;
            end else if (push_i && !busy_q && (push_off == PAGE_AW'(g))) begin
                valid_q[g] <= 1'b1;
                pbuf[g]    <= push_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            tmr_q  <= '0;
            idx_q  <= '0;
        end else if (busy_q) begin
            tmr_q <= tmr_q + 1'b1;
            if (!idx_q[PAGE_AW]) begin
                idx_q <= idx_q + 1'b1;
            end
            if (clear) begin
                busy_q <= 1'b0;
                pend_q <= 1'b0;
            end
        end else begin
            if (push_i) begin
                page_q <= push_addr_i[ADDR_W-1:PAGE_AW];
                pend_q <= 1'b1;
            end
            if (go_i && pend_q) begin
                busy_q <= 1'b1;
                tmr_q  <= '0;
                idx_q  <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_full[STORE_AW-1:0]] <= pbuf[idx_q[PAGE_AW-1:0]];
        end
    end

    assign rd_data_o = store[rd_addr_i[STORE_AW-1:0]];
    assign busy_o    = busy_q;

    // R7
    push_idle_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !push_i);

    // R7
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(go_i));

endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
    import eeprom_twi_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int PAGE_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              push_o,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic [7:0]        push_data_o,
    output logic              go_o
);

    phase_e            phase;
    step_e             step;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [7:0]        txsh;
    logic [7:0]        ahi;
    logic [ADDR_W-1:0] addr;
    logic              reading;
    logic              mack;
    logic              oe;
    logic [15:0]       word_full;

    assign word_full = {ahi, shreg};

    always_ff @(posedge clk) begin
        push_o <= 1'b0;
        go_o   <= 1'b0;
        if (rst) begin
            phase       <= PH_IDLE;
            step        <= STP_DEV;
            cnt         <= '0;
            shreg       <= '0;
            txsh        <= '0;
            ahi         <= '0;
            addr        <= '0;
            reading     <= 1'b0;
            mack        <= 1'b0;
            oe          <= 1'b0;
            push_addr_o <= '0;
            push_data_o <= '0;
        end else if (ev.start) begin
            phase <= PH_RX;
            step  <= STP_DEV;
            cnt   <= '0;
            oe    <= 1'b0;
        end else if (ev.stop) begin
            phase <= PH_IDLE;
            oe    <= 1'b0;
            go_o  <= 1'b1;
        end else begin
            case (phase)
                PH_RX: begin
                    if (ev.rise) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (ev.fall && cnt == 4'd8) begin
                        case (step)
                            STP_DEV: begin
                                if (dev_match(shreg, strap_i) && !busy_i) begin
                                    oe      <= 1'b1;
                                    phase   <= PH_ACK;
                                    reading <= shreg[0];
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            STP_AHI: begin
                                ahi   <= shreg;
                                oe    <= 1'b1;
                                phase <= PH_ACK;
                                step  <= STP_ALO;
                            end
                            STP_ALO: begin
                                addr  <= word_full[ADDR_W-1:0];
                                oe    <= 1'b1;
                                phase <= PH_ACK;
                                step  <= STP_DATA;
                            end
                            default: begin
                                push_o      <= 1'b1;
                                push_addr_o <= addr;
                                push_data_o <= shreg;
                                addr[PAGE_AW-1:0] <= addr[PAGE_AW-1:0] + PAGE_AW'(1);
                                oe    <= 1'b1;
                                phase <= PH_ACK;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (step == STP_DEV && reading) begin
                            phase <= PH_TX;
                            txsh  <= rd_data_i;
                            oe    <= !rd_data_i[7];
                        end else begin
                            oe    <= 1'b0;
                            phase <= PH_RX;
                            if (step == STP_DEV) begin
                                step <= STP_AHI;
                            end
                        end
                    end
                end
                PH_TX: begin
                    if (ev.fall) begin
                        if (cnt == 4'd7) begin
                            oe    <= 1'b0;
                            phase <= PH_MACK;
                            addr  <= addr + ADDR_W'(1);
                            cnt   <= '0;
                        end else begin
                            cnt  <= cnt + 4'd1;
                            txsh <= {txsh[6:0], 1'b0};
                            oe   <= !txsh[6];
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.rise) begin
                        mack <= !ev.sda;
                    end else if (ev.fall) begin
                        if (mack) begin
                            phase <= PH_TX;
                            txsh  <= rd_data_i;
                            oe    <= !rd_data_i[7];
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o  = oe;
    assign rd_addr_o = addr;

    // R4
    sda_change_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe) |-> !$past(ev.scl));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !oe);

    // R7
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACK && step == STP_DEV) |-> !busy_i);

    // R6
    push_page_chk: assert property (@(posedge clk) disable iff (rst)
        push_o |=> (addr[ADDR_W-1:PAGE_AW] == $past(push_addr_o[ADDR_W-1:PAGE_AW])));

endmodule

// File: rtl/eeprom_twi_target.sv
module eeprom_twi_target
    import eeprom_twi_pkg::*;
#(
    parameter bit LARGE_ARRAY = 1'b0,
    parameter int STORE_AW    = 10,
    parameter int PAGE_AW     = 6,
    parameter int WR_CYCLES   = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_oe_o
);

    localparam int ADDR_W = LARGE_ARRAY ? 15 : 14;

    bus_ev_t           ev;
    logic              busy;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              push;
    logic [ADDR_W-1:0] push_addr;
    logic [7:0]        push_data;
    logic              go;

    twi_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    twi_target_fsm #(
        .ADDR_W  (ADDR_W),
        .PAGE_AW (PAGE_AW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .strap_i     (strap_i),
        .busy_i      (busy),
        .rd_data_i   (rd_data),
        .sda_oe_o    (sda_oe_o),
        .rd_addr_o   (rd_addr),
        .push_o      (push),
        .push_addr_o (push_addr),
        .push_data_o (push_data),
        .go_o        (go)
    );

    twi_commit_engine #(
        .ADDR_W    (ADDR_W),
        .STORE_AW  (STORE_AW),
        .PAGE_AW   (PAGE_AW),
        .WR_CYCLES (WR_CYCLES)
    ) u_commit (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .push_addr_i (push_addr),
        .push_data_i (push_data),
        .go_i        (go),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .busy_o      (busy)
    );

endmodule

// File: tb/eeprom_twi_target_tb_top.sv
module eeprom_twi_target_tb_top;

    localparam int H = 8;
    localparam logic [7:0] SEL_W = 8'hA2;
    localparam logic [7:0] SEL_R = 8'hA3;
    localparam logic [23:0] VEC [4] = '{
        {16'h0005, 8'h3C},
        {16'hC123, 8'h81},
        {16'h2200, 8'hE7},
        {16'h5377, 8'h09}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst;
    logic scl;
    logic m_low;
    logic sda_line;
    logic sda_oe;
    logic [1:0] strap;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    assign sda_line = !(m_low || sda_oe);

    eeprom_twi_target dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(H/2);
        scl = 1'b1;   wt(H/2);
        m_low = 1'b1; wt(H/2);
        scl = 1'b0;   wt(H/2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(H/2);
        scl = 1'b1;   wt(H/2);
        m_low = 1'b0; wt(H/2);
    endtask

    task automatic send_bit(input bit b);
        m_low = !b; wt(H/2);
        scl = 1'b1; wt(H);
        scl = 1'b0; wt(H/2);
    endtask

    task automatic recv_bit(output bit b);
        m_low = 1'b0; wt(H/2);
        scl = 1'b1;   wt(H/2);
        b = sda_line; wt(H/2);
        scl = 1'b0;   wt(H/2);
    endtask

    task automatic write_byte(input logic [7:0] v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(input bit ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!ack);
        m_low = 1'b0;
    endtask

    task automatic set_addr(input logic [15:0] a, input string req);
        bit k;
        bus_start();
        write_byte(SEL_W, k);   chk(k, req, k, 1);
        write_byte(a[15:8], k); chk(k, req, k, 1);
        write_byte(a[7:0], k);  chk(k, req, k, 1);
    endtask

    task automatic poll_ready();
        bit k = 0;
        int tries = 0;
        while (!k && tries < 60) begin
            bus_start();
            write_byte(SEL_W, k);
            bus_stop();
            tries++;
        end
        chk(k, "R7 commit completes", k, 1);
    endtask

    task automatic rand_read(input logic [15:0] a, input logic [7:0] exp, input string req);
        bit k;
        logic [7:0] v;
        set_addr(a, "R9 address phase ack");
        bus_start();
        write_byte(SEL_R, k);
        chk(k, "R9 read select ack", k, 1);
        read_byte(1'b0, v);
        bus_stop();
        chk(v == exp, req, v, exp);
    endtask

    task automatic write_bytes(input logic [15:0] a, input logic [31:0] d, input int n);
        bit k;
        set_addr(a, "R5 write address ack");
        for (int i = 0; i < n; i++) begin
            write_byte(d[31-8*i -: 8], k);
            chk(k, "R4 data byte ack", k, 1);
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit k;
        logic [7:0] v;
        rst = 1'b1; scl = 1'b1; m_low = 1'b0; strap = 2'b01;
        wt(10);
        rst = 1'b0;
        wt(4);
        chk(sda_oe == 1'b0, "R1 reset releases data", sda_oe, 0);

        // Table: byte write, immediate busy poll, then random read (R5, R6, R7, R9)
        for (int i = 0; i < 4; i++) begin
            write_bytes(VEC[i][23:8], {VEC[i][7:0], 24'h0}, 1);
            bus_start();
            write_byte(SEL_W, k);
            bus_stop();
            chk(!k, "R7 busy select not acked", k, 0);
            poll_ready();
            rand_read({2'b00, VEC[i][21:8]}, VEC[i][7:0], "R5 R9 random read data");
        end

        // R11 aliasing above the store width
        rand_read(16'h0405, 8'h3C, "R11 alias read");

        // R10 sequential read of a page write, R8 current address
        write_bytes(16'h0040, 32'h11223344, 4);
        poll_ready();
        set_addr(16'h0040, "R10 address ack");
        bus_start();
        write_byte(SEL_R, k);
        for (int i = 0; i < 4; i++) begin
            read_byte(i < 3, v);
            chk(v == 8'h11 * (i + 1), "R10 sequential data", v, 8'h11 * (i + 1));
        end
        bus_stop();
        rand_read(16'h0041, 8'h22, "R9 single byte");
        bus_start();
        write_byte(SEL_R, k);
        read_byte(1'b0, v);
        bus_stop();
        chk(v == 8'h33, "R8 current address read", v, 8'h33);

        // R6 page rollover
        write_bytes(16'h017E, 32'hAABBCC00, 3);
        poll_ready();
        rand_read(16'h0140, 8'hCC, "R6 page wrap third byte");
        rand_read(16'h017F, 8'hBB, "R6 page end byte");

        // R10 counter wrap at top of address space
        write_bytes(16'h3FFF, 32'h5A000000, 1);
        poll_ready();
        write_bytes(16'h0000, 32'hA5000000, 1);
        poll_ready();
        set_addr(16'h3FFF, "R10 wrap address ack");
        bus_start();
        write_byte(SEL_R, k);
        read_byte(1'b1, v);
        chk(v == 8'h5A, "R10 top byte", v, 8'h5A);
        read_byte(1'b0, v);
        bus_stop();
        chk(v == 8'hA5, "R10 wrap to zero", v, 8'hA5);

        // R3 foreign strap value: silent until next start
        bus_start();
        write_byte(8'hA4, k);
        chk(!k, "R3 foreign select nack", k, 0);
        write_byte(SEL_W, k);
        chk(!k, "R3 ignored until start", k, 0);
        bus_stop();
        chk(sda_oe == 1'b0, "R2 stop releases data", sda_oe, 0);

        // R7 address-only write starts no commit
        set_addr(16'h0040, "R7 address-only ack");
        bus_stop();
        bus_start();
        write_byte(SEL_W, k);
        bus_stop();
        chk(k, "R7 no commit after address-only write", k, 1);

        // R2 start in mid-byte restarts framing; current address is 0x0040
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(SEL_W[7-i]);
        bus_start();
        write_byte(SEL_R, k);
        chk(k, "R2 restart select ack", k, 1);
        read_byte(1'b0, v);
        bus_stop();
        chk(v == 8'h11, "R2 R8 read after restart", v, 8'h11);

        wt(20);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule